// File: doc/BRIEF.md
# Wake-up Power Switch Controller

This block lives in the always-on standby domain. It watches a small set of wake-up pads and drives one power-enable output that controls the switch feeding the core supply. While the power enable is high the core is powered. Software lowers the output with a register write just before it enters ultra-low-power standby. A wake-up event on any armed pad then raises the output again, and the core comes back up.

Each pad has its own pad-select bit, which hands the pad to the wake-up logic or leaves it as a general-purpose I/O. Each pad also has a 4-bit trigger code, built from a mode pair and a polarity pair, and a sticky status bit that software reads and clears. Pad inputs pass through a synchronizer before detection. The power enable is latched: only a software write can clear it, and only a wake-up event can set it.

A small register port with combinational read data carries all configuration. Four registers sit at word addresses 0 to 3: trigger codes, pad select, status and power.

Top module: `wk_power_switch`

## Requirements
- R1: After reset `pwr_en_o` is 1, every trigger code is 0, every pad-select bit is 0 and every status bit is 0.
- R2: Address 0 holds the trigger codes. Pad i uses bits [4i+3:4i]. Within a code, bit 0 means edge mode, bit 1 means level mode, bit 2 means active-high and bit 3 means active-low. The legal codes are 5 (rising edge), 6 (high level), 9 (falling edge) and 10 (low level).
- R3: A pad with code 5 detects a 0-to-1 change of its synchronized sample. The detection sets that pad's status bit and drives `pwr_en_o` high.
- R4: A pad with code 9 detects a 1-to-0 change of its synchronized sample. A 0-to-1 change causes no detection.
- R5: A pad with code 6 detects on every cycle in which its synchronized sample is 1.
- R6: A pad with code 10 detects on every cycle in which its synchronized sample is 0.
- R7: Address 1 bit i is the pad-select bit for pad i (1 means wake-up logic, 0 means general I/O). The value is also driven on `pad_sel_o`. A pad whose select bit is 0 never sets status and never raises `pwr_en_o`.
- R8: Any trigger code other than 5, 6, 9 or 10 (for example 0, 7 or 13) disables detection for that pad.
- R9: Address 2 bit i is pad i's status bit, where 1 means asserted. A bit stays set until software writes 1 to it, and writing 0 leaves it unchanged. A detection in the same cycle as the clear keeps the bit set.
- R10: Writing 1 to address 3 bit 0 drives `pwr_en_o` low on the next cycle. The output then stays low until a detection. A detection in the same cycle as that write keeps the output high. Writing 0 there has no effect.
- R11: A pad change that is captured at clock edge k raises `pwr_en_o` after edge k+2: two synchronizer flops, then the registered output.
- R12: `rdata_o` combinationally returns the register selected by `addr_i`. Address 3 returns `pwr_en_o` in bit 0. Unused upper bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Standby-domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pad_i | input | NUM_IN | Raw wake-up pad levels |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word address |
| wdata_i | input | DATA_W | Register write data |
| rdata_o | output | DATA_W | Read data for `addr_i` |
| pwr_en_o | output | 1 | Core supply enable, 1 = core on |
| pad_sel_o | output | NUM_IN | Pad ownership, 1 = wake-up logic |

## Verification
The assertions check, on every cycle, the latch rules of the power enable: it falls only after a sleep write, and it is high in the cycle after any detection. They also check that status bits never drop without a clear write, and that a newly set status bit always traces back to a selected pad holding a legal code. Only the bench's scenarios can show the detection types themselves: a falling-edge pad ignoring a rise, a level pad re-asserting through a clear, and the exact two-edge synchronizer latency. The same holds for field placement inside the code word and for the read-back values. A behavioural model checks all of these on every clock.

// File: rtl/wk_pkg.sv
package wk_pkg;

   localparam int CODE_W = 4;
   localparam int REG_AW = 2;

   // bit positions inside a trigger code
   localparam int BIT_EDGE  = 0;
   localparam int BIT_LEVEL = 1;
   localparam int BIT_HIGH  = 2;
   localparam int BIT_LOW   = 3;

   typedef enum logic [REG_AW-1:0] {
      REG_CFG  = 2'd0,
      REG_SEL  = 2'd1,
      REG_STAT = 2'd2,
      REG_PWR  = 2'd3
   } reg_e;

   typedef enum logic [CODE_W-1:0] {
      TRIG_RISE = 4'd5,
      TRIG_HIGH = 4'd6,
      TRIG_FALL = 4'd9,
      TRIG_LOW  = 4'd10
   } trig_e;

   typedef struct packed {
      logic valid;
      logic edge_mode;
      logic act_high;
   } trig_t;

   // exactly one mode bit and one polarity bit make a legal code
   function automatic trig_t decode_code(input logic [CODE_W-1:0] code);
      trig_t t;
      t.valid     = (code[BIT_EDGE] ^ code[BIT_LEVEL]) & (code[BIT_HIGH] ^ code[BIT_LOW]);
      t.edge_mode = code[BIT_EDGE];
      t.act_high  = code[BIT_HIGH];
      return t;
   endfunction

   function automatic logic code_legal(input logic [CODE_W-1:0] code);
      trig_t t;
      t = decode_code(code);
      return t.valid;
   endfunction

endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
   parameter int   WIDTH   = 4,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   localparam logic [WIDTH-1:0] RST_VEC = {WIDTH{RST_VAL}};

   initial begin
      assert (STAGES >= 1 && WIDTH >= 1)
         else $error("wk_sync: STAGES and WIDTH must be at least 1");
   end

   generate
      if (STAGES == 1) begin : g_single
         logic [WIDTH-1:0] flop_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) flop_q <= RST_VEC;
            else         flop_q <= d_i;
         end
         assign q_o = flop_q;
      end else begin : g_chain
         logic [WIDTH-1:0] chain_q [STAGES];
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VEC;
            end else begin
               chain_q[0] <= d_i;
               for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
            end
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/wk_detect.sv
module wk_detect
   import wk_pkg::*;
#(
   parameter logic PREV_RST = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sample_i,
   input  logic              sel_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              hit_o
);

   trig_t trig;
   logic  prev_q;
   logic  edge_hit;
   logic  level_hit;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= PREV_RST;
      else         prev_q <= sample_i;
   end

   always_comb begin
      trig      = decode_code(code_i);
      edge_hit  = trig.act_high ? (sample_i & ~prev_q) : (~sample_i & prev_q);
      level_hit = trig.act_high ? sample_i : ~sample_i;
      hit_o     = sel_i & trig.valid & (trig.edge_mode ? edge_hit : level_hit);
   end

   // an edge-mode detection cannot repeat while the sample holds still (R3, R4)
   p_edge_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_o && trig.edge_mode && $stable(code_i)) |=> !(hit_o && $stable(sample_i) && $stable(code_i)));

endmodule

// File: rtl/wk_regs.sv
module wk_regs
   import wk_pkg::*;
#(
   parameter int NUM_IN = 4,
   parameter int DATA_W = 32
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     wr_en_i,
   input  logic [REG_AW-1:0]        addr_i,
   input  logic [DATA_W-1:0]        wdata_i,
   input  logic [NUM_IN-1:0]        hit_i,
   output logic [NUM_IN*CODE_W-1:0] cfg_o,
   output logic [NUM_IN-1:0]        sel_o,
   output logic [NUM_IN-1:0]        stat_o,
   output logic                     pwr_o,
   output logic [DATA_W-1:0]        rdata_o
);

   localparam int CFG_W = NUM_IN * CODE_W;

   logic [CFG_W-1:0]  cfg_q;
   logic [NUM_IN-1:0] sel_q;
   logic [NUM_IN-1:0] stat_q;
   logic              pwr_q;
   logic              wr_cfg, wr_sel, wr_stat, sleep_wr;
   logic [NUM_IN-1:0] clr_mask;
   logic              wake_any;
   logic              unused_wdata_bits;

   assign unused_wdata_bits = ^wdata_i;

   always_comb begin
      wr_cfg   = wr_en_i && (reg_e'(addr_i) == REG_CFG);
      wr_sel   = wr_en_i && (reg_e'(addr_i) == REG_SEL);
      wr_stat  = wr_en_i && (reg_e'(addr_i) == REG_STAT);
      sleep_wr = wr_en_i && (reg_e'(addr_i) == REG_PWR) && wdata_i[0];
      clr_mask = wr_stat ? wdata_i[NUM_IN-1:0] : '0;
      wake_any = |hit_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_q  <= '0;
         sel_q  <= '0;
         stat_q <= '0;
         pwr_q  <= 1'b1;
      end else begin
         if (wr_cfg) cfg_q <= wdata_i[CFG_W-1:0];
         if (wr_sel) sel_q <= wdata_i[NUM_IN-1:0];
         stat_q <= (stat_q & ~clr_mask) | hit_i;
         if (wake_any)      pwr_q <= 1'b1;
         else if (sleep_wr) pwr_q <= 1'b0;
      end
   end

   always_comb begin
      rdata_o = '0;
      case (reg_e'(addr_i))
         REG_CFG:  rdata_o[CFG_W-1:0]  = cfg_q;
         REG_SEL:  rdata_o[NUM_IN-1:0] = sel_q;
         REG_STAT: rdata_o[NUM_IN-1:0] = stat_q;
         REG_PWR:  rdata_o[0]          = pwr_q;
         default:  rdata_o             = '0;
      endcase
   end

   assign cfg_o  = cfg_q;
   assign sel_o  = sel_q;
   assign stat_o = stat_q;
   assign pwr_o  = pwr_q;

   p_stat_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

   p_wake_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_any |=> (pwr_q && ((stat_q & $past(hit_i)) == $past(hit_i))));

   p_sleep_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sleep_wr && !wake_any) |=> !pwr_q);

   p_pwr_fall_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pwr_q) |-> $past(sleep_wr));

endmodule

// File: rtl/wk_power_switch.sv
module wk_power_switch
   import wk_pkg::*;
#(
   parameter int NUM_IN      = 4,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NUM_IN-1:0] pad_i,
   input  logic              wr_en_i,
   input  logic [1:0]        addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              pwr_en_o,
   output logic [NUM_IN-1:0] pad_sel_o
);

   localparam int CFG_W = NUM_IN * CODE_W;

   initial begin
      assert (NUM_IN >= 1 && NUM_IN <= 4)
         else $error("wk_power_switch: NUM_IN must be 1 to 4");
      assert (DATA_W >= CFG_W)
         else $error("wk_power_switch: DATA_W too narrow for the trigger codes");
      assert (SYNC_STAGES >= 1)
         else $error("wk_power_switch: SYNC_STAGES must be at least 1");
   end

   logic [NUM_IN-1:0] sync_w;
   logic [NUM_IN-1:0] hit_w;
   logic [NUM_IN-1:0] sel_w;
   logic [NUM_IN-1:0] stat_w;
   logic [CFG_W-1:0]  cfg_w;
   logic              pwr_w;

   wk_sync #(
      .WIDTH   (NUM_IN),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b0)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pad_i),
      .q_o    (sync_w)
   );

   generate
      for (genvar i = 0; i < NUM_IN; i++) begin : g_in
         wk_detect #(.PREV_RST(1'b0)) u_det (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .sample_i (sync_w[i]),
            .sel_i    (sel_w[i]),
            .code_i   (cfg_w[i*CODE_W +: CODE_W]),
            .hit_o    (hit_w[i])
         );

         p_sel_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(stat_w[i]) |-> $past(sel_w[i]));

         p_legal_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(stat_w[i]) |-> $past(code_legal(cfg_w[i*CODE_W +: CODE_W])));
      end
   endgenerate

   wk_regs #(
      .NUM_IN (NUM_IN),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (wr_en_i),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .hit_i   (hit_w),
      .cfg_o   (cfg_w),
      .sel_o   (sel_w),
      .stat_o  (stat_w),
      .pwr_o   (pwr_w),
      .rdata_o (rdata_o)
   );

   assign pwr_en_o  = pwr_w;
   assign pad_sel_o = sel_w;

   // a rise of the power enable always follows a newly set or held status (R11)
   p_rise_has_status_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pwr_en_o) |-> (stat_w != '0));

endmodule

// File: tb/wk_power_switch_tb_top.sv
module wk_power_switch_tb_top;

   localparam int N  = 4;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pad = '0;
   logic          wr_en = 1'b0;
   logic [1:0]    addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          pwr_en;
   logic [N-1:0]  pad_sel;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   wk_power_switch #(.NUM_IN(N), .DATA_W(DW), .SYNC_STAGES(2)) dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .pad_i     (pad),
      .wr_en_i   (wr_en),
      .addr_i    (addr),
      .wdata_i   (wdata),
      .rdata_o   (rdata),
      .pwr_en_o  (pwr_en),
      .pad_sel_o (pad_sel)
   );

   // ---------------- reference model ----------------
   logic [4*N-1:0] m_cfg;
   logic [N-1:0]   m_sel, m_stat;
   logic           m_pwr;
   logic [N-1:0]   hq[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cfg = '0; m_sel = '0; m_stat = '0; m_pwr = 1'b1;
         hq = '{'0, '0, '0};
      end else begin
         logic [N-1:0] hits;
         logic [N-1:0] clr;
         hits = '0;
         for (int i = 0; i < N; i++) begin
            logic cur, prv;
            logic [3:0] c;
            cur = hq[1][i];
            prv = hq[0][i];
            c   = m_cfg[i*4 +: 4];
            if (m_sel[i]) begin
               case (c)
                  4'd5:    hits[i] = cur && !prv;
                  4'd9:    hits[i] = !cur && prv;
                  4'd6:    hits[i] = cur;
                  4'd10:   hits[i] = !cur;
                  default: hits[i] = 1'b0;
               endcase
            end
         end
         clr = (wr_en && addr == 2'd2) ? wdata[N-1:0] : '0;
         m_stat = (m_stat & ~clr) | hits;
         if (hits != '0) m_pwr = 1'b1;
         else if (wr_en && addr == 2'd3 && wdata[0]) m_pwr = 1'b0;
         if (wr_en && addr == 2'd0) m_cfg = wdata[4*N-1:0];
         if (wr_en && addr == 2'd1) m_sel = wdata[N-1:0];
         hq.push_back(pad);
         void'(hq.pop_front());
      end
   end

   function automatic logic [DW-1:0] exp_rd(input logic [1:0] a);
      logic [DW-1:0] v;
      v = '0;
      case (a)
         2'd0: v[4*N-1:0] = m_cfg;
         2'd1: v[N-1:0]   = m_sel;
         2'd2: v[N-1:0]   = m_stat;
         default: v[0]    = m_pwr;
      endcase
      return v;
   endfunction

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // per-cycle comparison, posedge + 3
   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         chk("R10 model pwr_en", {31'b0, pwr_en}, {31'b0, m_pwr});
         chk("R7 model pad_sel", {28'b0, pad_sel}, {28'b0, m_sel});
         chk("R12 model rdata", rdata, exp_rd(addr));
      end
   end

   // ---------------- stimulus helpers (phase posedge + 1) ----------------
   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); #1;
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [DW-1:0] v);
      addr = a;
      #1;
      v = rdata;
      @(posedge clk); #1;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         finish_run();
      end
   end

   initial begin
      logic [DW-1:0] v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick(1);

      // R1 reset state
      chk("R1 pwr_en after reset", {31'b0, pwr_en}, 32'd1);
      rd(2'd0, v); chk("R1 cfg after reset", v, 32'd0);
      rd(2'd1, v); chk("R1 sel after reset", v, 32'd0);
      rd(2'd2, v); chk("R1 status after reset", v, 32'd0);

      // R10 sleep write
      wr(2'd3, 32'd1);
      chk("R10 sleep drives pwr low", {31'b0, pwr_en}, 32'd0);
      wr(2'd3, 32'd0);
      chk("R10 write 0 no effect", {31'b0, pwr_en}, 32'd0);

      // R3 / R11 rising edge on pad 0
      wr(2'd0, 32'h0005);
      wr(2'd1, 32'h1);
      rd(2'd0, v); chk("R2 cfg readback", v, 32'h0005);
      chk("R12 pad_sel_o", {28'b0, pad_sel}, 32'h1);
      pad[0] = 1'b1;
      tick(2);
      chk("R11 pwr still low one edge early", {31'b0, pwr_en}, 32'd0);
      tick(1);
      chk("R11 pwr high two edges after capture", {31'b0, pwr_en}, 32'd1);
      rd(2'd2, v); chk("R3 status bit0 set", v, 32'h1);

      // R9 sticky / W1C
      wr(2'd2, 32'h0);
      rd(2'd2, v); chk("R9 write 0 keeps status", v, 32'h1);
      wr(2'd2, 32'h1);
      rd(2'd2, v); chk("R9 write 1 clears status", v, 32'h0);
      rd(2'd3, v); chk("R12 pwr readback", v, 32'h1);

      // R4 falling edge on pad 1
      wr(2'd0, 32'h0095);
      wr(2'd1, 32'h3);
      wr(2'd3, 32'd1);
      pad[1] = 1'b1;
      tick(5);
      chk("R4 rise ignored by falling code", {31'b0, pwr_en}, 32'd0);
      pad[1] = 1'b0;
      tick(3);
      chk("R4 falling edge wakes", {31'b0, pwr_en}, 32'd1);
      rd(2'd2, v); chk("R4 status bit1 set", v, 32'h2);

      // R5 level high on pad 2
      wr(2'd2, 32'hF);
      wr(2'd0, 32'h0695);
      wr(2'd1, 32'h7);
      wr(2'd3, 32'd1);
      chk("R5 pwr low before level", {31'b0, pwr_en}, 32'd0);
      pad[2] = 1'b1;
      tick(3);
      chk("R5 high level wakes", {31'b0, pwr_en}, 32'd1);
      wr(2'd2, 32'h4);
      rd(2'd2, v); chk("R9 detection beats clear", v, 32'h4);
      wr(2'd3, 32'd1);
      chk("R10 wake beats sleep write", {31'b0, pwr_en}, 32'd1);
      pad[2] = 1'b0;
      tick(4);
      wr(2'd2, 32'hF);
      rd(2'd2, v); chk("R5 status clears after level drops", v, 32'h0);

      // R6 level low on pad 3
      wr(2'd0, 32'hA095);
      wr(2'd3, 32'd1);
      chk("R6 pwr low while pad3 unselected", {31'b0, pwr_en}, 32'd0);
      wr(2'd1, 32'hB);
      tick(2);
      chk("R6 low level wakes", {31'b0, pwr_en}, 32'd1);
      rd(2'd2, v); chk("R6 status bit3 set", v, 32'h8);
      pad[3] = 1'b1;
      tick(4);
      wr(2'd2, 32'hF);
      tick(2);
      rd(2'd2, v); chk("R6 no status once pad3 high", v, 32'h0);

      // R7 unselected pad ignored
      wr(2'd0, 32'h0005);
      wr(2'd1, 32'h0);
      chk("R7 pad_sel_o cleared", {28'b0, pad_sel}, 32'h0);
      pad[0] = 1'b0;
      tick(4);
      wr(2'd3, 32'd1);
      pad[0] = 1'b1;
      tick(5);
      chk("R7 unselected rise ignored", {31'b0, pwr_en}, 32'd0);
      rd(2'd2, v); chk("R7 unselected no status", v, 32'h0);

      // R8 illegal codes
      wr(2'd0, 32'h00D0);
      wr(2'd1, 32'h2);
      pad[1] = 1'b1; tick(4);
      pad[1] = 1'b0; tick(4);
      chk("R8 code 13 ignored", {31'b0, pwr_en}, 32'd0);
      wr(2'd0, 32'h0070);
      pad[1] = 1'b1; tick(4);
      chk("R8 code 7 ignored", {31'b0, pwr_en}, 32'd0);
      wr(2'd0, 32'h0000);
      pad[1] = 1'b0; tick(4);
      rd(2'd2, v); chk("R8 no status for illegal codes", v, 32'h0);

      // R2 field position: code 5 in field 1 arms pad 1
      wr(2'd0, 32'h0050);
      pad[1] = 1'b1;
      tick(3);
      chk("R2 field1 rising arms pad1", {31'b0, pwr_en}, 32'd1);
      rd(2'd2, v); chk("R2 status bit1 from field1", v, 32'h2);

      tick(2);
      finish_run();
   end

endmodule